// File: doc/BRIEF.md
# Hierarchical Endian Swap Unit

This block reorders one 128-bit memory beat per transfer. A 4-bit swap control travels with each beat. Each control bit turns on one exchange stage, and each stage works at a single element size: bytes, 16-bit halfwords, 32-bit words or 64-bit halves. Because the four stages can be enabled in any mix, they reach sixteen distinct lane permutations of the beat. These range from a plain pass-through to a full reversal of all sixteen bytes.

Put another way, output byte i takes input byte (i XOR ctrl). Every stage flips one bit of the byte index. For this reason the stages commute, and the order in which they are chained does not matter.

Data and control enter together on a valid/ready stream. The reordered beat leaves one cycle later on a second valid/ready stream. Its output register holds the beat steady whenever the consumer stalls.

Top module: `endian_swap_unit`

## Requirements
- R1: With `in_ctrl[3]` set and the other control bits clear, bytes 15..8 of the beat trade places with bytes 7..0 (the two 64-bit halves are exchanged).
- R2: With only `in_ctrl[2]` set, the two 32-bit words inside each 64-bit lane are exchanged.
- R3: With only `in_ctrl[1]` set, the two 16-bit halfwords inside each 32-bit word are exchanged.
- R4: With only `in_ctrl[0]` set, the two bytes inside each 16-bit halfword are exchanged.
- R5: A control value of 0 delivers the beat unchanged.
- R6: A control value of 4'hF delivers the beat with all 16 bytes in reverse order.
- R7: Any mix of control bits gives output byte i (bits 8i+7..8i) equal to input byte (i XOR ctrl).
- R8: A beat accepted when `in_valid` and `in_ready` are both high at a rising edge appears with `out_valid` high right after that edge, and beats leave in the order they were accepted.
- R9: While `out_valid` is high and `out_ready` is low, `in_ready` is low. In the following cycle `out_valid` stays high and `out_data` is unchanged.
- R10: The control is captured with each beat, so back-to-back beats with different controls are each reordered by their own control.
- R11: While `rst` is high at a rising edge, `out_valid` is low after that edge and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input beat present |
| in_ready | output | 1 | Unit can take a beat this cycle |
| in_data | input | 128 | Input beat |
| in_ctrl | input | 4 | Swap control for this beat, bit k enables the exchange of 8·2^k-bit elements |
| out_valid | output | 1 | Output beat present |
| out_ready | input | 1 | Consumer takes the output beat |
| out_data | output | 128 | Reordered beat |

## Verification
The assertions assume that `rst` is held high for at least one edge before traffic starts. They also assume that `out_ready` and the input signals are stable around the rising edge. They make no assumption that an offered beat is held while `in_ready` is low, because the unit samples only what it accepts. The stimulus therefore redraws `in_data`, `in_ctrl`, `in_valid` and `out_ready` freely on the falling edge, and the scoreboard counts a beat only when it has actually been accepted.

// File: rtl/esu_pkg.sv
package esu_pkg;

    // Default beat geometry
    localparam int BEAT_W   = 128;
    localparam int LANE_W   = 8;
    localparam int LANES    = BEAT_W / LANE_W;
    localparam int SEL_W    = $clog2(LANES);

    typedef logic [BEAT_W-1:0] beat_t;
    typedef logic [SEL_W-1:0]  sel_t;

    // Element width handled by swap stage k
    function automatic int stage_elem_w(input int k);
        return LANE_W << k;
    endfunction

endpackage

// File: rtl/esu_pair_swap.sv
// One exchange stage: swaps adjacent ELEM_W-bit elements in every 2*ELEM_W group.
module esu_pair_swap #(
    parameter int DATA_W = esu_pkg::BEAT_W,
    parameter int ELEM_W = esu_pkg::LANE_W
) (
    input  logic              en,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout
);
    localparam int PAIR_W = 2 * ELEM_W;
    localparam int PAIRS  = DATA_W / PAIR_W;

    logic [DATA_W-1:0] swapped;

    for (genvar p = 0; p < PAIRS; p++) begin : g_pair
        assign swapped[p*PAIR_W +: ELEM_W]          = din[p*PAIR_W + ELEM_W +: ELEM_W];
        assign swapped[p*PAIR_W + ELEM_W +: ELEM_W] = din[p*PAIR_W +: ELEM_W];
    end

    assign dout = en ? swapped : din;

endmodule

// File: rtl/esu_swap_net.sv
// Chain of exchange stages, one per control bit, finest granularity first.
module esu_swap_net #(
    parameter int DATA_W = esu_pkg::BEAT_W,
    parameter int LANE_W = esu_pkg::LANE_W,
    localparam int SEL_W = $clog2(DATA_W / LANE_W)
) (
    input  logic [SEL_W-1:0]  sel,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout
);
    logic [DATA_W-1:0] chain [SEL_W+1];

    assign chain[0] = din;

    for (genvar k = 0; k < SEL_W; k++) begin : g_stage
        esu_pair_swap #(
            .DATA_W (DATA_W),
            .ELEM_W (LANE_W << k)
        ) u_stage (
            .en   (sel[k]),
            .din  (chain[k]),
            .dout (chain[k+1])
        );
    end

    assign dout = chain[SEL_W];

endmodule

// File: rtl/esu_out_stage.sv
// Single-entry output register with valid/ready flow control.
module esu_out_stage #(
    parameter int DATA_W = esu_pkg::BEAT_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [DATA_W-1:0] in_data,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [DATA_W-1:0] out_data
);
    assign in_ready = !out_valid || out_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else if (in_ready) begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_data <= in_data;
            end
        end
    end

    // R9: a stalled beat stays put
    assert_hold_stable_R9: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_ready |=> out_valid && $stable(out_data));

    // R9: no new beat is taken while stalled
    assert_no_take_on_stall_R9: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_ready |-> !in_ready);

    // R11: reset empties the register
    assert_reset_empty_R11: assert property (@(posedge clk)
        rst |=> !out_valid);

endmodule

// File: rtl/endian_swap_unit.sv
module endian_swap_unit #(
    parameter int DATA_W = esu_pkg::BEAT_W,
    parameter int LANE_W = esu_pkg::LANE_W,
    localparam int LANES = DATA_W / LANE_W,
    localparam int SEL_W = $clog2(LANES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [DATA_W-1:0] in_data,
    input  logic [SEL_W-1:0]  in_ctrl,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [DATA_W-1:0] out_data
);
    logic [DATA_W-1:0] swapped;

    esu_swap_net #(
        .DATA_W (DATA_W),
        .LANE_W (LANE_W)
    ) u_net (
        .sel  (in_ctrl),
        .din  (in_data),
        .dout (swapped)
    );

    esu_out_stage #(
        .DATA_W (DATA_W)
    ) u_out (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .in_data   (swapped),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_data  (out_data)
    );

    // Reference lane reversal, built lane by lane, for the full-swap check
    logic [DATA_W-1:0] lane_rev;
    always_comb begin
        for (int i = 0; i < LANES; i++) begin
            lane_rev[i*LANE_W +: LANE_W] = in_data[(LANES-1-i)*LANE_W +: LANE_W];
        end
    end

    logic in_fire;
    assign in_fire = in_valid && in_ready;

    // R8: accepted beat is presented on the next cycle
    assert_one_cycle_R8: assert property (@(posedge clk) disable iff (rst)
        in_fire |=> out_valid);

    // R5: zero control is identity
    assert_passthru_R5: assert property (@(posedge clk) disable iff (rst)
        in_fire && (in_ctrl == '0) |=> out_data == $past(in_data));

    // R6: all-ones control reverses every lane
    assert_full_rev_R6: assert property (@(posedge clk) disable iff (rst)
        in_fire && (in_ctrl == '1) |=> out_data == $past(lane_rev));

endmodule

// File: tb/endian_swap_unit_tb.sv
module endian_swap_unit_tb;
    localparam int CLK_PERIOD = 10;
    localparam int DW = 128;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           in_valid = 1'b0;
    logic           in_ready;
    logic [DW-1:0]  in_data = '0;
    logic [3:0]     in_ctrl = '0;
    logic           out_valid;
    logic           out_ready = 1'b0;
    logic [DW-1:0]  out_data;

    int checks = 0;
    int fails  = 0;

    logic [DW-1:0] q_data [$];
    string         q_tag  [$];
    logic          stall_pend = 1'b0;
    logic [DW-1:0] stall_data = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    endian_swap_unit u_dut (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .in_data   (in_data),
        .in_ctrl   (in_ctrl),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_data  (out_data)
    );

    // Output byte i comes from input byte (i XOR ctrl)
    function automatic logic [DW-1:0] expect_beat(input logic [DW-1:0] d, input logic [3:0] c);
        logic [DW-1:0] r;
        for (int i = 0; i < 16; i++) begin
            r[i*8 +: 8] = d[(i ^ int'(c))*8 +: 8];
        end
        return r;
    endfunction

    task automatic check(input logic ok, input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    task automatic step(input logic v, input logic [DW-1:0] d, input logic [3:0] c,
                        input logic rdy, input string tag);
        @(negedge clk);
        if (stall_pend) begin
            check(out_valid && out_data == stall_data, "R9 held beat", out_data, stall_data);
        end
        in_valid  = v;
        in_data   = d;
        in_ctrl   = c;
        out_ready = rdy;
        #1;
        if (out_valid && !out_ready) begin
            check(!in_ready, "R9 in_ready low while stalled", {127'd0, in_ready}, '0);
            stall_pend = 1'b1;
            stall_data = out_data;
        end else begin
            stall_pend = 1'b0;
        end
        if (in_valid && in_ready) begin
            q_data.push_back(expect_beat(d, c));
            q_tag.push_back(tag);
        end
        if (out_valid && out_ready) begin
            if (q_data.size() == 0) begin
                check(1'b0, "R8 unexpected output beat", out_data, '0);
            end else begin
                logic [DW-1:0] e;
                string t;
                e = q_data.pop_front();
                t = q_tag.pop_front();
                check(out_data == e, t, out_data, e);
            end
        end
    endtask

    function automatic logic [DW-1:0] rnd128();
        return {$urandom, $urandom, $urandom, $urandom};
    endfunction

    initial begin
        #(CLK_PERIOD * 150000);
        fails++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        logic [DW-1:0] pat;
        void'($urandom(32'h5EED_0042));
        pat = 128'h0F0E0D0C_0B0A0908_07060504_03020100;

        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        // R11: reset state
        check(!out_valid, "R11 out_valid after reset", {127'd0, out_valid}, '0);
        check(in_ready, "R11 in_ready after reset", {127'd0, in_ready}, 128'd1);

        // R8: one-cycle latency
        step(1'b1, pat, 4'h0, 1'b0, "R5 identity");
        check(!out_valid, "R8 no output before edge", {127'd0, out_valid}, '0);
        @(negedge clk);
        check(out_valid, "R8 output one cycle later", {127'd0, out_valid}, 128'd1);
        step(1'b0, '0, 4'h0, 1'b1, "none");

        // Directed single-stage and corner controls
        step(1'b1, pat,      4'h8, 1'b1, "R1 halves");
        step(1'b1, pat,      4'h4, 1'b1, "R2 words");
        step(1'b1, pat,      4'h2, 1'b1, "R3 halfwords");
        step(1'b1, pat,      4'h1, 1'b1, "R4 bytes");
        step(1'b1, rnd128(), 4'h0, 1'b1, "R5 identity");
        step(1'b1, pat,      4'hF, 1'b1, "R6 full reversal");
        step(1'b1, rnd128(), 4'hF, 1'b1, "R6 full reversal");
        step(1'b1, pat,      4'h6, 1'b1, "R7 combined");
        step(1'b1, pat,      4'hA, 1'b1, "R7 combined");
        // R10: control changes beat to beat
        step(1'b1, pat,      4'h3, 1'b1, "R10 per-beat ctrl");
        step(1'b1, pat,      4'hC, 1'b1, "R10 per-beat ctrl");
        step(1'b1, pat,      4'h0, 1'b1, "R10 per-beat ctrl");
        step(1'b1, pat,      4'h5, 1'b1, "R10 per-beat ctrl");
        // R9: consumer stall with producer pushing
        step(1'b1, rnd128(), 4'h9, 1'b0, "R9 stall");
        step(1'b1, rnd128(), 4'h7, 1'b0, "R9 stall");
        step(1'b1, rnd128(), 4'hE, 1'b0, "R9 stall");
        step(1'b1, rnd128(), 4'hB, 1'b1, "R9 stall");
        step(1'b0, '0,       4'h0, 1'b1, "none");

        // Random traffic, random stalls
        for (int n = 0; n < 3000; n++) begin
            step(($urandom % 4) != 0, rnd128(), 4'($urandom), ($urandom % 3) != 0,
                 "R7 R10 random");
        end

        // Drain
        for (int n = 0; n < 4; n++) begin
            step(1'b0, '0, 4'h0, 1'b1, "none");
        end
        check(q_data.size() == 0, "R8 all accepted beats delivered",
              128'(q_data.size()), '0);
        summary();
    end

endmodule